// File: doc/BRIEF.md
# Three-Stage Merged Comb Decimator

This block lowers the sample rate of a signed sample stream by the product D1·D2·D3 without a single multiplier. Conceptually it is three decimating stages in a row. The first stage applies three all-ones FIR sections of length D1 and then keeps one sample in D1. The second stage applies four sections of length D2 and keeps one in D2. The third stage applies five sections of length D3 and keeps one in D3. Each all-ones section of length L has transfer (1−z^−L)/(1−z^−1). It is realised as a running-sum accumulator on the fast side of a rate switch and a first difference on the slow side.

The accumulators and differences are moved across the rate switches. Where a stage's differences meet the next stage's accumulators, they cancel in pairs. What remains is three accumulators at the input rate, one accumulator after the first drop, one after the second drop, and five first differences at the output rate. All internal arithmetic is two's complement and wraps. Because the width is sized for the total DC gain, the wrapped result is still exact.

Input and output are valid/ready streams. A sample is taken when `in_valid` and `in_ready` are both high at a clock edge. A result is handed over when `out_valid` and `out_ready` are both high at a clock edge. While an unaccepted result is pending, the block holds `in_ready` low, so back-pressure on the output stalls the whole datapath. Each stage has a modulo counter that produces its rate strobe, and downstream state advances only on that strobe.

Top module: `merged_comb_decimator`

## Requirements
- R1: A synchronous reset clears every accumulator, difference delay, phase counter and the output register. After reset, `out_valid` is 0 and `in_ready` is 1, and no output depends on any sample accepted before the reset.
- R2: Idle cycles (`in_valid` low) and output stalls change neither the output values nor the order of the outputs. Only the sequence of accepted samples matters.
- R3: Number accepted samples x[n] from 0 after reset. Let y be x filtered by three length-D1 all-ones sections, then kept at indices n ≡ D1−1 (mod D1). Filter that result by four length-D2 sections and keep indices ≡ D2−1 (mod D2). Filter that by five length-D3 sections and keep indices ≡ D3−1 (mod D3). Output k equals element k of the final sequence, as a signed value of IN_W plus the gain bits.
- R4: Exactly one output is produced per D1·D2·D3 accepted samples. Output k becomes valid on the cycle after sample (k+1)·D1·D2·D3−1 is accepted.
- R5: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, `out_data` holds its value, and no internal state advances.
- R6: Full-scale inputs of either sign produce exact outputs with no overflow. The output width is IN_W plus 3·clog2(D1)+4·clog2(D2)+5·clog2(D3) bits.
- R7: After a handshake, `out_valid` drops on the next cycle unless a new result completes on that edge.
- R8: A constant input v gives, once the filter has settled, a constant output v·D1^3·D2^4·D3^5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Decimated result pending |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | IN_W+gain bits | Signed decimated result |

## Verification
Some properties are checked on every cycle by assertions. During a stall, the held result must stay fixed and the first-rate accumulator state must not move. Each phase counter must stay below its ratio and return to zero after its strobe. A new result must appear only after the final-rate strobe, and a taken result must be cleared when nothing replaces it. The numerical behaviour can only be shown by the bench scenarios: exact filter values, the sample-to-output alignment, full-scale headroom and DC gain. The bench sweeps impulse, both full-scale constants, an alternating extreme pattern and pseudo-random data through a small configuration. It uses random gaps and stalls, and compares each result with a direct-form cascade computed arithmetically.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  // comb section counts per conceptual stage
  localparam int FIRST_ORDER  = 3;
  localparam int SECOND_ORDER = 4;
  localparam int THIRD_ORDER  = 5;
  // sections that survive pairwise cancellation
  localparam int RATE1_INTEGS = SECOND_ORDER - FIRST_ORDER;
  localparam int RATE2_INTEGS = THIRD_ORDER - SECOND_ORDER;

  // upper bound on log2 of the DC gain d1^3 * d2^4 * d3^5
  function automatic int gain_bits(input int d1, input int d2, input int d3);
    return FIRST_ORDER * $clog2(d1) + SECOND_ORDER * $clog2(d2)
         + THIRD_ORDER * $clog2(d3);
  endfunction
endpackage

// File: rtl/mcd_integrators.sv
module mcd_integrators #(
  parameter int W = 32,
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] acc_q [N];
  logic [W-1:0] acc_d [N];

  // running sums chained in one cycle so the kept sample includes din
  always_comb begin
    acc_d[0] = acc_q[0] + din;
    for (int i = 1; i < N; i++) acc_d[i] = acc_q[i] + acc_d[i-1];
  end

  assign dout = acc_d[N-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) acc_q[i] <= '0;
    end else if (en) begin
      for (int i = 0; i < N; i++) acc_q[i] <= acc_d[i];
    end
  end
endmodule

// File: rtl/mcd_strobe.sv
module mcd_strobe #(
  parameter int D = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (D > 2) ? $clog2(D) : 1;
  localparam logic [CW-1:0] LAST = CW'(D - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (en)   cnt <= tick ? '0 : cnt + 1'b1;
  end

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == '0));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    en && !tick |=> (cnt != '0) && (cnt <= LAST));
endmodule

// File: rtl/mcd_differencers.sv
module mcd_differencers #(
  parameter int W = 32,
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] dly_q [N];
  logic [W-1:0] stg   [N+1];

  always_comb begin
    stg[0] = din;
    for (int i = 0; i < N; i++) stg[i+1] = stg[i] - dly_q[i];
  end

  assign dout = stg[N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) dly_q[i] <= '0;
    end else if (en) begin
      for (int i = 0; i < N; i++) dly_q[i] <= stg[i];
    end
  end
endmodule

// File: rtl/merged_comb_decimator.sv
module merged_comb_decimator
  import mcd_pkg::*;
#(
  parameter int IN_W = 16,
  parameter int D1   = 4,
  parameter int D2   = 2,
  parameter int D3   = 2,
  localparam int W   = IN_W + gain_bits(D1, D2, D3)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_data
);
  localparam int EXT = W - IN_W;

  logic         take, tick1, tick2, tick3;
  logic [W-1:0] din_ext, r0_out, r1_out, r2_out, diff_out;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign din_ext  = {{EXT{in_data[IN_W-1]}}, in_data};

  // input rate: accumulators of the first stage
  mcd_integrators #(.W(W), .N(FIRST_ORDER)) u_int0 (
    .clk(clk), .rst(rst), .en(take), .din(din_ext), .dout(r0_out));
  mcd_strobe #(.D(D1)) u_tick1 (
    .clk(clk), .rst(rst), .en(take), .tick(tick1));

  // after the first drop: second-stage accumulators left after cancellation
  mcd_integrators #(.W(W), .N(RATE1_INTEGS)) u_int1 (
    .clk(clk), .rst(rst), .en(tick1), .din(r0_out), .dout(r1_out));
  mcd_strobe #(.D(D2)) u_tick2 (
    .clk(clk), .rst(rst), .en(tick1), .tick(tick2));

  // after the second drop
  mcd_integrators #(.W(W), .N(RATE2_INTEGS)) u_int2 (
    .clk(clk), .rst(rst), .en(tick2), .din(r1_out), .dout(r2_out));
  mcd_strobe #(.D(D3)) u_tick3 (
    .clk(clk), .rst(rst), .en(tick2), .tick(tick3));

  // output rate: all remaining first differences
  mcd_differencers #(.W(W), .N(THIRD_ORDER)) u_diff (
    .clk(clk), .rst(rst), .en(tick3), .din(r2_out), .dout(diff_out));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (tick3) begin
      out_valid <= 1'b1;
      out_data  <= diff_out;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R5
  stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(u_int0.acc_q[FIRST_ORDER-1]));

  // R4
  valid_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(tick3));

  // R7
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !tick3 |=> !out_valid);
endmodule

// File: tb/merged_comb_decimator_test.sv
`timescale 1ns/1ps
module merged_comb_decimator_test;
  localparam int IN_W = 6;
  localparam int D1 = 2, D2 = 3, D3 = 2;
  localparam int DT = D1 * D2 * D3;
  localparam int W = IN_W + 3*$clog2(D1) + 4*$clog2(D2) + 5*$clog2(D3);
  localparam int NIN = 240;
  localparam int NOUT = NIN / DT;
  localparam longint GAIN = longint'(D1**3) * longint'(D2**4) * longint'(D3**5);

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [IN_W-1:0] in_data = '0;
  logic [W-1:0] out_data;

  int n_checks = 0, n_fail = 0;
  longint xs [NIN];
  longint wa [NIN];
  longint wb [NIN];
  longint expv [NOUT];

  always #2 clk = ~clk;

  merged_comb_decimator #(.IN_W(IN_W), .D1(D1), .D2(D2), .D3(D3)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  task automatic chk(input bit ok, input string req, input longint act, input longint ex);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, ex);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // direct-form model: moving sums then decimation, stage by stage
  task automatic boxcar(input int len, input int l);
    for (int n = 0; n < len; n++) begin
      longint s = 0;
      for (int j = 0; j < l; j++) if (n - j >= 0) s += wa[n-j];
      wb[n] = s;
    end
    for (int n = 0; n < len; n++) wa[n] = wb[n];
  endtask

  task automatic keep(inout int len, input int d);
    for (int m = 0; m < len / d; m++) wa[m] = wa[m*d + d - 1];
    len = len / d;
  endtask

  task automatic build_expected();
    int len = NIN;
    for (int n = 0; n < NIN; n++) wa[n] = xs[n];
    for (int r = 0; r < 3; r++) boxcar(len, D1);
    keep(len, D1);
    for (int r = 0; r < 4; r++) boxcar(len, D2);
    keep(len, D2);
    for (int r = 0; r < 5; r++) boxcar(len, D3);
    keep(len, D3);
    for (int k = 0; k < NOUT; k++) expv[k] = wa[k];
  endtask

  task automatic run_pattern(input int p, input bit gaps);
    int iidx = 0, oidx = 0, cyc = 0;
    for (int n = 0; n < NIN; n++) begin
      case (p)
        0: xs[n] = (n == 5) ? 31 : 0;
        1: xs[n] = 31;
        2: xs[n] = -32;
        3: xs[n] = (n % 2 == 0) ? 31 : -32;
        default: xs[n] = longint'($urandom % 64) - 32;
      endcase
    end
    build_expected();
    @(negedge clk);
    rst = 1; in_valid = 0; out_ready = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    #1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
    while (oidx < NOUT && cyc < 6000) begin
      bit ih, oh;
      @(negedge clk);
      in_valid  = (iidx < NIN) && (!gaps || ($urandom % 4 != 0));
      in_data   = xs[(iidx < NIN) ? iidx : 0][IN_W-1:0];
      out_ready = !gaps || ($urandom % 3 != 0);
      #1;
      ih = in_valid && in_ready;
      oh = out_valid && out_ready;
      if (out_valid && !out_ready)
        chk(in_ready == 1'b0, "R5 in_ready low while stalled", longint'(in_ready), 0);
      if (oh) begin
        longint act = longint'($signed(out_data));
        string tag = gaps ? "R2 R3 output value" : (p == 1 || p == 2) ? "R6 R3 output value" : "R3 output value";
        chk(act == expv[oidx], tag, act, expv[oidx]);
        chk(iidx >= (oidx+1)*DT && iidx < (oidx+2)*DT, "R4 output alignment",
            longint'(iidx), longint'((oidx+1)*DT));
        if ((p == 1 || p == 2) && oidx == NOUT - 1)
          chk(act == xs[0] * GAIN, "R8 settled DC gain", act, xs[0] * GAIN);
        oidx++;
      end
      if (ih) iidx++;
      cyc++;
    end
    chk(oidx == NOUT, "R4 output count", longint'(oidx), longint'(NOUT));
    @(negedge clk);
    in_valid = 0; out_ready = 1;
    #1;
    chk(out_valid == 1'b0, "R7 valid drops after handshake", longint'(out_valid), 0);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    run_pattern(0, 0);
    run_pattern(1, 0);
    run_pattern(2, 1);
    run_pattern(3, 1);
    run_pattern(4, 0);
    run_pattern(4, 1);
    run_pattern(1, 1);
    finish_run();
  end
endmodule